// File: doc/BRIEF.md
# Cell Word Alignment Synchronizer

This block sits after a one-to-sixteen bit demultiplexer, where the sixteen lanes reach it with an unknown lane rotation and an unknown word phase relative to the cell boundary. A cell is 64 bytes, carried as 32 words of 16 bits. The first word of every cell holds a parameterised 8-bit sync pattern in its upper byte. While hunting, the block tests every valid input word under all sixteen lane rotations. The first word that carries the pattern fixes both the lane rotation and the cell phase.

Once locked, the block undoes the rotation on every word. It counts 32 valid words per cell and emits a regenerated frame pulse with each head word. At every expected head position it checks the pattern again. One or two consecutive misses are treated as jitter and do not disturb the output. The third consecutive miss ends the lock, and the search starts again.

Top module: `cell_word_aligner`

## Requirements
- R1: During and immediately after reset, `out_valid`, `out_frame` and `locked` are low.
- R2: While unlocked, `out_valid` and `out_frame` stay low, except on the word that achieves lock.
- R3: While unlocked, a valid word locks the block if some rotation r in 0..15 gives a derotated word d, with d[i] = in[(i+r) mod 16], whose bits [15:8] equal the sync pattern (default 8'hB8). When several rotations match, the lowest r is used. That word is output as the head of a cell, and `locked` rises with it.
- R4: Each output word is the input word derotated by the locked rotation, as defined in R3. It appears with `out_valid` high two clock cycles after the input was sampled, and this latency is constant.
- R5: `out_frame` is high with the head word and then with every 32nd valid output word after it, and never without `out_valid`.
- R6: A cycle with `in_valid` low produces no output word and does not advance the cell position.
- R7: While locked, a head word whose derotated upper byte misses the pattern is still output with `out_frame`, provided fewer than three consecutive misses have occurred. A matching head word resets the miss count to zero.
- R8: The third consecutive head miss drops `locked` in that word's output cycle, and that word is not output. This holds even if the word matches at another rotation. Hunting resumes with the next valid word.
- R9: While locked, the rotation does not change, even if payload words match the pattern at other rotations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Demultiplexed lane word, unknown rotation |
| in_valid | input | 1 | in_data carries a word this cycle |
| out_data | output | 16 | Realigned cell word |
| out_valid | output | 1 | out_data holds a cell word |
| out_frame | output | 1 | Marks the first word of a cell |
| locked | output | 1 | Alignment is established |

## Verification
The third consecutive head miss and a fresh pattern match can fall on the same word: the miss ends the lock, while the match would start a new one. The bench builds that word so it carries the pattern at a rotation other than the locked one. It then checks that the word produces no output and that `locked` falls. Lock must return only on a later head word. Random runs also place input gaps next to head words, so that the cell counter and the error counter are judged while both are active.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } align_st_e;
endpackage

// File: rtl/cwa_matcher.sv
module cwa_matcher #(
  parameter int W = 16,
  parameter int SW = 8,
  parameter logic [SW-1:0] PAT = 8'hB8,
  localparam int RW = $clog2(W)
) (
  input  logic [W-1:0]  word,
  input  logic [RW-1:0] sel_rot,
  output logic          hit_any,
  output logic [RW-1:0] hit_rot,
  output logic          hit_sel,
  output logic [W-1:0]  sel_word
);
  logic [W-1:0] rot_words [W];
  logic [W-1:0] match;

  // one derotated view and one comparator per candidate lane shift
  for (genvar r = 0; r < W; r++) begin : g_rot
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign rot_words[r][i] = word[(i + r) % W];
    end
    assign match[r] = (rot_words[r][W-1 -: SW] == PAT);
  end

  // lowest matching rotation wins
  always_comb begin
    hit_any = 1'b0;
    hit_rot = '0;
    for (int r = W - 1; r >= 0; r--) begin
      if (match[r]) begin
        hit_any = 1'b1;
        hit_rot = RW'(r);
      end
    end
  end

  assign hit_sel  = match[sel_rot];
  assign sel_word = rot_words[sel_rot];
endmodule

// File: rtl/cwa_ctrl.sv
module cwa_ctrl
  import cwa_pkg::*;
#(
  parameter int CELL_WORDS = 32,
  parameter int MISS_LIMIT = 3,
  parameter int RW = 4,
  localparam int CW = $clog2(CELL_WORDS),
  localparam int EW = $clog2(MISS_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic          hit_any,
  input  logic [RW-1:0] hit_rot,
  input  logic          hit_sel,
  output logic [RW-1:0] sel_rot,
  output logic          emit_valid,
  output logic          emit_frame,
  output logic          locked
);
  localparam logic [CW-1:0] LAST = CW'(CELL_WORDS - 1);

  align_st_e     st_q, st_d;
  logic [RW-1:0] rot_q, rot_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] err_q, err_d;

  assign locked  = (st_q == ST_LOCK);
  assign sel_rot = locked ? rot_q : hit_rot;

  always_comb begin
    st_d       = st_q;
    rot_d      = rot_q;
    cnt_d      = cnt_q;
    err_d      = err_q;
    emit_valid = 1'b0;
    emit_frame = 1'b0;
    if (vld) begin
      if (!locked) begin
        if (hit_any) begin
          st_d       = ST_LOCK;
          rot_d      = hit_rot;
          cnt_d      = CW'(1);
          err_d      = '0;
          emit_valid = 1'b1;
          emit_frame = 1'b1;
        end
      end else begin
        cnt_d      = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        emit_valid = 1'b1;
        if (cnt_q == '0) begin
          if (hit_sel) begin
            err_d      = '0;
            emit_frame = 1'b1;
          end else if (err_q == EW'(MISS_LIMIT - 1)) begin
            st_d       = ST_HUNT;
            err_d      = '0;
            emit_valid = 1'b0;
          end else begin
            err_d      = err_q + 1'b1;
            emit_frame = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_HUNT;
      rot_q <= '0;
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      st_q  <= st_d;
      rot_q <= rot_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  // R8: lock is abandoned only after the limit-th consecutive miss
  assert_drop_after_limit_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(err_q) == EW'(MISS_LIMIT - 1)));
  // R7: miss count never reaches the limit while held
  assert_miss_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    err_q < EW'(MISS_LIMIT));
  // R9: rotation frozen while lock persists
  assert_rot_held_R9: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(rot_q));
endmodule

// File: rtl/cell_word_aligner.sv
module cell_word_aligner #(
  parameter int DATA_W = 16,
  parameter int SYNC_W = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hB8,
  parameter int CELL_WORDS = 32,
  parameter int MISS_LIMIT = 3,
  localparam int RW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_frame,
  output logic              locked
);
  logic [DATA_W-1:0] in_q;
  logic              vld_q;
  logic              hit_any, hit_sel, emit_valid, emit_frame;
  logic [RW-1:0]     hit_rot, sel_rot;
  logic [DATA_W-1:0] sel_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      in_q  <= in_data;
      vld_q <= in_valid;
    end
  end

  cwa_matcher #(.W(DATA_W), .SW(SYNC_W), .PAT(SYNC_PAT)) u_match (
    .word    (in_q),
    .sel_rot (sel_rot),
    .hit_any (hit_any),
    .hit_rot (hit_rot),
    .hit_sel (hit_sel),
    .sel_word(sel_word)
  );

  cwa_ctrl #(.CELL_WORDS(CELL_WORDS), .MISS_LIMIT(MISS_LIMIT), .RW(RW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .vld       (vld_q),
    .hit_any   (hit_any),
    .hit_rot   (hit_rot),
    .hit_sel   (hit_sel),
    .sel_rot   (sel_rot),
    .emit_valid(emit_valid),
    .emit_frame(emit_frame),
    .locked    (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_frame <= 1'b0;
    end else begin
      out_data  <= sel_word;
      out_valid <= emit_valid;
      out_frame <= emit_frame;
    end
  end

  assert_frame_in_valid_R5: assert property (@(posedge clk) disable iff (rst)
    out_frame |-> out_valid);
  assert_frame_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    out_frame |=> !out_frame);
  assert_out_needs_lock_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> locked);
  assert_lock_opens_cell_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> out_frame);
  assert_gap_silent_R6: assert property (@(posedge clk) disable iff (rst)
    !vld_q |=> !out_valid);
endmodule

// File: tb/tb_cell_word_aligner.sv
module tb_cell_word_aligner;
  localparam logic [7:0] PAT = 8'hB8;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] in_data;
  logic        in_valid;
  logic [15:0] out_data;
  logic        out_valid, out_frame, locked;

  always #2 clk = ~clk;

  cell_word_aligner dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .out_frame(out_frame),
    .locked(locked)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit       m_lock = 0;
  int       m_rot = 0, m_cnt = 0, m_err = 0;
  // two-stage expectation pipe: a = newest, b = oldest
  bit [15:0] ea_d, eb_d;
  bit ea_v, ea_f, ea_l, eb_v, eb_f, eb_l;

  function automatic bit [15:0] derot(bit [15:0] w, int r);
    bit [15:0] o;
    for (int i = 0; i < 16; i++) o[i] = w[(i + r) % 16];
    return o;
  endfunction

  function automatic bit [15:0] rotl(bit [15:0] w, int r);
    bit [15:0] o;
    for (int i = 0; i < 16; i++) o[(i + r) % 16] = w[i];
    return o;
  endfunction

  function automatic int find_rot(bit [15:0] w);
    for (int r = 0; r < 16; r++) if (derot(w, r)[15:8] == PAT) return r;
    return -1;
  endfunction

  task automatic check(string tag, bit c, string what, int act, int exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit [15:0] w, bit v, string tag);
    bit nv, nf;
    bit [15:0] nd;
    int r;
    @(negedge clk);
    check(tag, out_valid == eb_v, "valid", out_valid, eb_v);
    check(tag, out_frame == eb_f, "frame", out_frame, eb_f);
    check(tag, locked == eb_l, "locked", locked, eb_l);
    if (eb_v) check(tag, out_data == eb_d, "data", out_data, eb_d);
    nv = 0; nf = 0; nd = 0;
    if (v) begin
      if (!m_lock) begin
        r = find_rot(w);
        if (r >= 0) begin
          m_lock = 1; m_rot = r; m_cnt = 1; m_err = 0;
          nv = 1; nf = 1; nd = derot(w, r);
        end
      end else begin
        nd = derot(w, m_rot);
        nv = 1;
        if (m_cnt == 0) begin
          if (nd[15:8] == PAT) begin m_err = 0; nf = 1; end
          else if (m_err == 2) begin m_lock = 0; m_err = 0; nv = 0; end
          else begin m_err++; nf = 1; end
        end
        m_cnt = (m_cnt + 1) % 32;
      end
    end
    eb_v = ea_v; eb_f = ea_f; eb_l = ea_l; eb_d = ea_d;
    ea_v = nv; ea_f = nf; ea_l = m_lock; ea_d = nd;
    in_data = w; in_valid = v;
  endtask

  // one cell: head word then 31 payload words, rotated by rot, optional gaps
  task automatic send_cell(int rot, bit head_ok, int gap_pct, string tag);
    bit [15:0] ideal;
    for (int k = 0; k < 32; k++) begin
      if (k == 0) ideal = {head_ok ? PAT : (PAT ^ 8'h01), 8'($urandom)};
      else ideal = 16'($urandom);
      while (int'($urandom % 100) < gap_pct) step(16'($urandom), 1'b0, tag);
      step(rotl(ideal, rot), 1'b1, tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    in_data = 0; in_valid = 0; rst = 1;
    ea_v = 0; ea_f = 0; ea_l = 0; ea_d = 0;
    eb_v = 0; eb_f = 0; eb_l = 0; eb_d = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", {out_valid, out_frame, locked} == 3'b000, "reset outs",
          {out_valid, out_frame, locked}, 0);
    @(negedge clk); rst = 0;
    step(16'h0, 1'b0, "R1");
    // R2: unmatched words give no output
    for (int k = 0; k < 10; k++) step(16'h0000, 1'b1, "R2");
    // R3/R4/R5: lock on rotation 5 after a phase offset of 3 words
    for (int k = 0; k < 3; k++) step(16'h0000, 1'b1, "R3");
    for (int c = 0; c < 4; c++) send_cell(5, 1'b1, 0, "R4");
    // R6: gaps inside cells
    for (int c = 0; c < 3; c++) send_cell(5, 1'b1, 30, "R6");
    // R9: payload carrying pattern at another rotation
    for (int k = 0; k < 32; k++) step(rotl({PAT, 8'h00}, 9), 1'b1, "R9");
    // R7: one miss, two misses, then recovery
    send_cell(5, 1'b0, 0, "R7");
    send_cell(5, 1'b1, 0, "R7");
    send_cell(5, 1'b0, 0, "R7");
    send_cell(5, 1'b0, 0, "R7");
    send_cell(5, 1'b1, 0, "R7");
    // R8: three misses; third head carries pattern at rotation 11
    send_cell(5, 1'b0, 0, "R8");
    send_cell(5, 1'b0, 0, "R8");
    step(rotl({PAT, 8'h00}, 11), 1'b1, "R8");
    for (int k = 0; k < 31; k++) step(16'h0000, 1'b1, "R8");
    send_cell(11, 1'b1, 10, "R3");
    // random mix
    for (int c = 0; c < 40; c++)
      send_cell(int'($urandom % 16), ($urandom % 4) != 0, 10, "R4");
    step(16'h0, 1'b0, "R6");
    step(16'h0, 1'b0, "R6");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule